// File: doc/BRIEF.md
# Critical-Conduction PFC Gate Controller

This block produces the gate command for the switch of a boost power-factor stage that runs in critical conduction mode. The switch turns on only when the inductor current has fallen to zero. The block sees this as a falling edge on a digitized zero-crossing comparator flag, which must follow a rising edge. The switch then stays on for a number of clock cycles taken from an on-time word. That word stands in for the voltage on the external compensation node. The block never drives the analog parts. The error amplifier, the comparators and the power stage stay outside, and the block exchanges plain level flags with them.

Four mechanisms keep the loop running safely:
- A watchdog restarts switching when no zero-crossing edge arrives.
- An over-voltage flag blanks the gate, and switching resumes with one forced pulse once the bus returns below the regulation flag.
- A gain scheduler picks the amplifier gain from the ballast mode and the bus flags.
- In run mode, a low bus raises an under-voltage request that the ballast sequencer uses to fall back to lockout.

The block has no streaming interface. Every input is a level that is sampled on each clock, so the block has no back-pressure rules.

Top module: `pfc_gate_ctrl`

## Requirements
- R1: While reset is held, the outputs are `pfc_gate` = 0, `gain_sel` = 2'd2 (high gain) and `uv_req` = 0.
- R2: `zx_in` passes through a two-flop synchronizer. A falling edge turns the gate on only if a rising edge was accepted after the last pulse began. If `zx_in` goes low just before clock edge k, the gate is high after edge k+2.
- R3: The length of the on-pulse, in clock cycles, is min(`ton_word`, TON_MAX), with a minimum of 1. The value is sampled when the pulse starts.
- R4: When `nzc_flag` is 1 at the start of a pulse, MOD_EXT cycles are added to the on-pulse length.
- R5: Zero-crossing edges that occur while the gate is high are ignored.
- R6: A falling zero-crossing edge with no accepted rising edge before it does not start a pulse.
- R7: After WD_CYCLES consecutive clock cycles with the gate low and the block enabled, a pulse of the programmed length is forced.
- R8: When `bus_above_ovp` is 1, the gate goes low on the next edge and stays low until `bus_above_ref` is 0. The edge that releases the gate also starts one pulse.
- R9: `gain_sel` (registered) is 2'd0 in run mode (`mode`=3). In preheat (`mode`=1) or ignition (`mode`=2) it is 2'd2 when `bus_above_ref`=1, 2'd1 when only `bus_above_min`=1, and 2'd2 otherwise. In lockout (`mode`=0) it is 2'd2.
- R10: `uv_req` (registered) is 1 exactly when `mode`=3, `bus_above_min`=0 and `fault`=0.
- R11: Lockout (`mode`=0) or `fault`=1 forces the gate low on the next edge. It also clears any arming and any over-voltage hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Ballast mode: 0 lockout, 1 preheat, 2 ignition, 3 run |
| fault | input | 1 | Ballast fault, holds gate low |
| zx_in | input | 1 | Zero-crossing comparator flag (asynchronous) |
| bus_above_min | input | 1 | Bus sense above the under-voltage level |
| bus_above_ref | input | 1 | Bus sense above the regulation level |
| bus_above_ovp | input | 1 | Bus sense above the over-voltage level |
| ton_word | input | TON_W | On-time request in clock cycles |
| nzc_flag | input | 1 | Line near its zero crossing: extend the on-time |
| pfc_gate | output | 1 | Switch gate command |
| gain_sel | output | 2 | Amplifier gain: 0 run, 1 low, 2 high |
| uv_req | output | 1 | Under-voltage request to the sequencer |

## Verification
The on-time is driven in two ways: clean rising-then-falling zero-crossing pulses, and no edges at all. Clean pulses give the synchronizer latency and the pulse length. With no edges, only the watchdog can produce the low gap that follows a pulse. On-time words above the cap, equal to zero, and combined with the near-zero flag separate saturation, the one-cycle floor and the extension from plain copying of the word. Edges that arrive during the on-time, and a falling edge whose rise happened during the on-time, show whether arming is tied to the off phase. Bus-flag sweeps in each ballast mode cover gain, over-voltage release and the under-voltage request, and faults are injected in the middle of a pulse.

// File: rtl/pfc_ctrl_pkg.sv
package pfc_ctrl_pkg;
  typedef enum logic [1:0] {
    BM_OFF     = 2'd0,
    BM_PREHEAT = 2'd1,
    BM_IGNITE  = 2'd2,
    BM_RUN     = 2'd3
  } ballast_mode_e;

  typedef enum logic [1:0] {
    GAIN_RUN  = 2'd0,
    GAIN_LOW  = 2'd1,
    GAIN_HIGH = 2'd2
  } gain_e;
endpackage

// File: rtl/pfc_zx_edge.sv
module pfc_zx_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic zx_raw,
  output logic zx_rise,
  output logic zx_fall
);
  localparam int LAST = STAGES;

  logic [LAST:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[LAST-1:0], zx_raw};
  end

  assign zx_rise = shreg[LAST-1] & ~shreg[LAST];
  assign zx_fall = ~shreg[LAST-1] & shreg[LAST];

  // R2: a detected rise reflects the raw input STAGES edges back
  p_rise_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    zx_rise |-> $past(zx_raw, STAGES))
    else $error("p_rise_origin_r2");
  p_fall_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    zx_fall |-> !$past(zx_raw, STAGES))
    else $error("p_fall_origin_r2");
endmodule

// File: rtl/pfc_ontime.sv
module pfc_ontime #(
  parameter int TON_W   = 8,
  parameter int TON_MAX = 40,
  parameter int MOD_EXT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [TON_W-1:0] ton_word,
  input  logic             nzc,
  output logic             gate_o
);
  localparam int LEN_MAX = TON_MAX + MOD_EXT;
  localparam int CNT_W   = $clog2(LEN_MAX + 1);

  logic [CNT_W-1:0] sat_len, ext_len, full_len, cnt_q;
  logic             gate_q;

  always_comb begin
    if (int'(ton_word) > TON_MAX) sat_len = CNT_W'(TON_MAX);
    else                          sat_len = CNT_W'(ton_word);
  end

  generate
    if (MOD_EXT > 0) begin : g_ext
      assign ext_len = nzc ? CNT_W'(MOD_EXT) : '0;
    end else begin : g_noext
      assign ext_len = '0;
    end
  endgenerate

  always_comb begin
    full_len = sat_len + ext_len;
    if (full_len == '0) full_len = CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      cnt_q  <= '0;
    end else if (abort) begin
      gate_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      gate_q <= 1'b1;
      cnt_q  <= full_len - CNT_W'(1);
    end else if (gate_q) begin
      if (cnt_q == '0) gate_q <= 1'b0;
      else             cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  assign gate_o = gate_q;

  // checker counter: length of the current high run
  logic [CNT_W:0] hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_run <= '0;
    else if (!gate_q) hi_run <= '0;
    else             hi_run <= hi_run + 1'b1;
  end

  // R3/R4: no pulse outlasts the capped length plus extension
  p_pulse_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q |-> (int'(hi_run) < LEN_MAX))
    else $error("p_pulse_cap_r3");
  // R3: a granted start raises the gate
  p_start_raises_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort) |=> gate_q)
    else $error("p_start_raises_r3");
endmodule

// File: rtl/pfc_gain_sched.sv
module pfc_gain_sched
  import pfc_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       fault_i,
  input  logic       bus_min_i,
  input  logic       bus_ref_i,
  output logic [1:0] gain_o,
  output logic       uv_o
);
  gain_e gain_d, gain_q;
  logic  uv_q;

  always_comb begin
    gain_d = GAIN_HIGH;
    if (mode_i == BM_RUN)                        gain_d = GAIN_RUN;
    else if (mode_i == BM_PREHEAT || mode_i == BM_IGNITE) begin
      if (bus_ref_i)      gain_d = GAIN_HIGH;
      else if (bus_min_i) gain_d = GAIN_LOW;
      else                gain_d = GAIN_HIGH;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= GAIN_HIGH;
      uv_q   <= 1'b0;
    end else begin
      gain_q <= gain_d;
      uv_q   <= (mode_i == BM_RUN) && !bus_min_i && !fault_i;
    end
  end

  assign gain_o = gain_q;
  assign uv_o   = uv_q;

  p_gain_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == BM_RUN) |=> (gain_o == GAIN_RUN))
    else $error("p_gain_run_r9");
  p_gain_mid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == BM_PREHEAT || mode_i == BM_IGNITE) && bus_min_i && !bus_ref_i)
      |=> (gain_o == GAIN_LOW))
    else $error("p_gain_mid_r9");
  p_uv_run_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    uv_o |-> ($past(mode_i) == BM_RUN && !$past(fault_i)))
    else $error("p_uv_run_only_r10");
endmodule

// File: rtl/pfc_gate_ctrl.sv
module pfc_gate_ctrl
  import pfc_ctrl_pkg::*;
#(
  parameter int TON_W     = 8,
  parameter int TON_MAX   = 40,
  parameter int MOD_EXT   = 4,
  parameter int WD_CYCLES = 20000,
  parameter int SYNC_STG  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             fault,
  input  logic             zx_in,
  input  logic             bus_above_min,
  input  logic             bus_above_ref,
  input  logic             bus_above_ovp,
  input  logic [TON_W-1:0] ton_word,
  input  logic             nzc_flag,
  output logic             pfc_gate,
  output logic [1:0]       gain_sel,
  output logic             uv_req
);
  localparam int WD_W = $clog2(WD_CYCLES);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(WD_CYCLES - 1);

  logic            zx_rise, zx_fall;
  logic            locked, abort, start, ovp_release, natural_go;
  logic            armed_q, ovp_hold_q;
  logic [WD_W-1:0] wd_cnt;

  pfc_zx_edge #(.STAGES(SYNC_STG)) u_zx (
    .clk     (clk),
    .rst_n   (rst_n),
    .zx_raw  (zx_in),
    .zx_rise (zx_rise),
    .zx_fall (zx_fall)
  );

  assign locked      = (mode == BM_OFF) || fault;
  assign abort       = locked || bus_above_ovp;
  assign ovp_release = ovp_hold_q && !bus_above_ref;
  assign natural_go  = !ovp_hold_q && !pfc_gate &&
                       ((zx_fall && armed_q) || (wd_cnt == WD_LAST));
  assign start       = !abort && (ovp_release || natural_go);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      ovp_hold_q <= 1'b0;
      wd_cnt     <= '0;
    end else if (locked) begin
      armed_q    <= 1'b0;
      ovp_hold_q <= 1'b0;
      wd_cnt     <= '0;
    end else if (bus_above_ovp) begin
      armed_q    <= 1'b0;
      ovp_hold_q <= 1'b1;
      wd_cnt     <= '0;
    end else if (ovp_hold_q) begin
      armed_q <= 1'b0;
      wd_cnt  <= '0;
      if (!bus_above_ref) ovp_hold_q <= 1'b0;
    end else if (pfc_gate) begin
      wd_cnt <= '0;
    end else if (start) begin
      armed_q <= 1'b0;
      wd_cnt  <= '0;
    end else begin
      if (zx_rise) armed_q <= 1'b1;
      wd_cnt <= wd_cnt + WD_W'(1);
    end
  end

  pfc_ontime #(.TON_W(TON_W), .TON_MAX(TON_MAX), .MOD_EXT(MOD_EXT)) u_ton (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .abort    (abort),
    .ton_word (ton_word),
    .nzc      (nzc_flag),
    .gate_o   (pfc_gate)
  );

  pfc_gain_sched u_gain (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode),
    .fault_i   (fault),
    .bus_min_i (bus_above_min),
    .bus_ref_i (bus_above_ref),
    .gain_o    (gain_sel),
    .uv_o      (uv_req)
  );

  p_locked_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> !pfc_gate)
    else $error("p_locked_low_r11");
  p_rise_enabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pfc_gate) |-> ($past(mode) != BM_OFF && !$past(fault)))
    else $error("p_rise_enabled_r11");
  p_ovp_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_above_ovp |=> !pfc_gate)
    else $error("p_ovp_blank_r8");
  p_wd_forces_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!abort && !ovp_hold_q && !pfc_gate && wd_cnt == WD_LAST) |=> pfc_gate)
    else $error("p_wd_forces_r7");
  p_on_ignores_zx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pfc_gate && !abort && !ovp_hold_q) |=> !armed_q)
    else $error("p_on_ignores_zx_r5");
endmodule

// File: tb/pfc_gate_ctrl_tb_top.sv
module pfc_gate_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TON_W      = 8;
  localparam int TMAX       = 40;
  localparam int EXT        = 4;
  localparam int WD         = 60;
  localparam int LIMIT      = 150000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       mode = 2'd0;
  logic             fault = 1'b0;
  logic             zx_in = 1'b0;
  logic             bmin = 1'b0, bref = 1'b0, bovp = 1'b0;
  logic [TON_W-1:0] ton = 8'd10;
  logic             nzc = 1'b0;
  logic             gate;
  logic [1:0]       gain;
  logic             uv;

  int    checks = 0;
  int    errs   = 0;
  int    cyc    = 0;
  string cur_req = "R1";

  // reference model state
  int m_gate = 0, m_cnt = 0, m_arm = 0, m_ovp = 0, m_wd = 0, m_gain = 2, m_uv = 0;
  int zh0 = 0, zh1 = 0, zh2 = 0;
  int e_rise, e_fall, e_len, e_lock;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfc_gate_ctrl #(.TON_W(TON_W), .TON_MAX(TMAX), .MOD_EXT(EXT), .WD_CYCLES(WD)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .fault(fault), .zx_in(zx_in),
    .bus_above_min(bmin), .bus_above_ref(bref), .bus_above_ovp(bovp),
    .ton_word(ton), .nzc_flag(nzc), .pfc_gate(gate), .gain_sel(gain), .uv_req(uv)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gate = 0; m_cnt = 0; m_arm = 0; m_ovp = 0; m_wd = 0; m_gain = 2; m_uv = 0;
      zh0 = 0; zh1 = 0; zh2 = 0;
    end else begin
      e_rise = (zh1 == 1 && zh2 == 0);
      e_fall = (zh1 == 0 && zh2 == 1);
      e_lock = (mode == 2'd0) || fault;
      e_len  = (int'(ton) > TMAX) ? TMAX : int'(ton);
      if (nzc) e_len += EXT;
      if (e_len == 0) e_len = 1;
      if (e_lock) begin
        m_gate = 0; m_cnt = 0; m_arm = 0; m_ovp = 0; m_wd = 0;
      end else if (bovp) begin
        m_ovp = 1; m_gate = 0; m_cnt = 0; m_arm = 0; m_wd = 0;
      end else if (m_ovp == 1) begin
        m_wd = 0; m_arm = 0;
        if (!bref) begin m_ovp = 0; m_gate = 1; m_cnt = e_len - 1; end
      end else if (m_gate == 1) begin
        m_wd = 0;
        if (m_cnt == 0) m_gate = 0; else m_cnt--;
      end else if ((e_fall && m_arm == 1) || m_wd == WD - 1) begin
        m_gate = 1; m_cnt = e_len - 1; m_arm = 0; m_wd = 0;
      end else begin
        if (e_rise) m_arm = 1;
        m_wd++;
      end
      if (mode == 2'd3) m_gain = 0;
      else if (mode == 2'd0) m_gain = 2;
      else if (bref) m_gain = 2;
      else if (bmin) m_gain = 1;
      else m_gain = 2;
      m_uv = (mode == 2'd3 && !bmin && !fault) ? 1 : 0;
      zh2 = zh1; zh1 = zh0; zh0 = zx_in;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    check(int'(gate) == m_gate, {cur_req, " gate"}, int'(gate), m_gate);
    check(int'(gain) == m_gain, {cur_req, " gain"}, int'(gain), m_gain);
    check(int'(uv) == m_uv, {cur_req, " uv_req"}, int'(uv), m_uv);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= LIMIT) begin
      checks++; errs++;
      $display("FAIL %s watchdog actual=%0d expected<%0d", cur_req, cyc, LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_gate(input logic v);
    for (int g = 0; g < 400 && gate != v; g++) @(negedge clk);
  endtask

  task automatic trigger();
    wait_gate(1'b0);
    zx_in = 1'b1; step(3);
    zx_in = 1'b0;
  endtask

  task automatic count_high(input int exp, input string tag);
    int n = 0;
    wait_gate(1'b1);
    while (gate == 1'b1 && n < 400) begin n++; @(negedge clk); end
    check(n == exp, tag, n, exp);
  endtask

  task automatic gap_low(input int exp, input string tag);
    int n = 0;
    wait_gate(1'b1);
    wait_gate(1'b0);
    while (gate == 1'b0 && n < 400) begin n++; @(negedge clk); end
    check(n == exp, tag, n, exp);
  endtask

  initial begin
    // R1: reset values
    step(2);
    check(gate == 1'b0, "R1 gate", int'(gate), 0);
    check(gain == 2'd2, "R1 gain", int'(gain), 2);
    check(uv == 1'b0, "R1 uv_req", int'(uv), 0);
    rst_n = 1'b1;

    // R11: lockout keeps the gate low despite edges
    cur_req = "R11";
    for (int i = 0; i < 4; i++) begin zx_in = 1'b1; step(4); zx_in = 1'b0; step(10); end
    step(30);

    // R2: clean zero-crossing pulses in preheat
    cur_req = "R2";
    mode = 2'd1; ton = 8'd10; step(3);
    for (int i = 0; i < 6; i++) begin zx_in = 1'b1; step(4); zx_in = 1'b0; step(14); end
    trigger();
    step(2);
    check(gate == 1'b0, "R2 before latency", int'(gate), 0);
    step(1);
    check(gate == 1'b1, "R2 latency", int'(gate), 1);

    // R3: saturation and one-cycle floor
    cur_req = "R3";
    ton = 8'd100; trigger(); count_high(TMAX, "R3 capped length");
    ton = 8'd0;   trigger(); count_high(1, "R3 floor length");
    ton = 8'd17;  trigger(); count_high(17, "R3 plain length");

    // R4: near-zero extension
    cur_req = "R4";
    ton = 8'd10; nzc = 1'b1; trigger(); count_high(10 + EXT, "R4 extended length");
    nzc = 1'b0;

    // R5 / R6: edges during on-time ignored; late fall without accepted rise
    cur_req = "R5";
    ton = 8'd20; trigger(); wait_gate(1'b1); step(2);
    zx_in = 1'b1; step(3); zx_in = 1'b0; step(3);
    zx_in = 1'b1;
    wait_gate(1'b0);
    cur_req = "R6";
    step(3); zx_in = 1'b0; step(20);
    check(gate == 1'b0, "R6 fall without rise", int'(gate), 0);

    // R7: watchdog gap
    cur_req = "R7";
    gap_low(WD, "R7 watchdog gap");

    // R8: over-voltage blanking and release pulse
    cur_req = "R8";
    ton = 8'd30; trigger(); wait_gate(1'b1); step(3);
    bovp = 1'b1; bref = 1'b1; bmin = 1'b1; step(1);
    check(gate == 1'b0, "R8 blank", int'(gate), 0);
    step(10); bovp = 1'b0; step(20);
    check(gate == 1'b0, "R8 hold", int'(gate), 0);
    bref = 1'b0;
    count_high(30, "R8 release pulse");

    // R9: gain schedule across modes and bus flags
    cur_req = "R9";
    for (int m = 1; m < 4; m++) begin
      mode = 2'(m);
      bmin = 1'b0; bref = 1'b0; step(3);
      bmin = 1'b1; bref = 1'b0; step(2);
      if (m != 3) check(gain == 2'd1, "R9 low gain", int'(gain), 1);
      bmin = 1'b1; bref = 1'b1; step(3);
      bmin = 1'b0; bref = 1'b1; step(3);
    end
    check(gain == 2'd0, "R9 run gain", int'(gain), 0);

    // R10: under-voltage request in run
    cur_req = "R10";
    mode = 2'd3; bmin = 1'b1; bref = 1'b0; step(5);
    bmin = 1'b0; step(2);
    check(uv == 1'b1, "R10 uv asserted", int'(uv), 1);
    fault = 1'b1; step(2);
    check(uv == 1'b0, "R10 uv masked by fault", int'(uv), 0);
    fault = 1'b0; bmin = 1'b1; step(3);

    // R11: fault mid-pulse, then lockout
    cur_req = "R11";
    mode = 2'd1; ton = 8'd30; trigger(); wait_gate(1'b1); step(2);
    fault = 1'b1; step(1);
    check(gate == 1'b0, "R11 fault drops gate", int'(gate), 0);
    step(5); fault = 1'b0; mode = 2'd0; step(WD + 10);
    check(gate == 1'b0, "R11 lockout low", int'(gate), 0);
    mode = 2'd2; step(WD + 30);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule